// File: doc/BRIEF.md
# Bit-Serial Memory-to-Memory Processor Core

This core has no data registers. Its only architectural state is an 8-bit program counter and three condition flags: carry, zero and negative. All data lives in a 32-byte RAM. Every instruction has the same form: read two RAM bytes, combine them, and write the result to a third RAM byte. The combining is done by a one-bit ALU that handles one bit per clock cycle, least significant bit first. Between the bit steps, a single carry bit is the only thing kept.

The program sits in an external instruction ROM. The core drives the ROM address from its program counter and takes the returned 18-bit word combinationally. RAM byte 31 is not storage: it is a window onto the program counter. Reading it gives the address of the executing instruction, so a program can make its own constants from its position. Writing it performs a jump. A conditional-move opcode turns that window into a conditional branch.

A test port lets the surrounding logic read any RAM byte. The program counter and the flags are driven out directly.

Top module: `bitSerialCpu`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the program counter, all three flags and every RAM byte to zero.
- R2: The instruction word has the opcode in bits [17:15], the destination address i in [14:10], the first source j in [9:5] and the second source k in [4:0]. The ROM is addressed by the program counter. Every instruction takes exactly 10 clock cycles: one fetch, eight bit steps and one commit. Its effects become visible after the tenth edge.
- R3: Opcodes 0 (AND), 1 (OR) and 2 (XOR) write the bitwise result of Mj and Mk to Mi. They update zero and negative and leave carry unchanged.
- R4: Opcode 3 (ADD) writes Mj+Mk. Opcode 4 (SUB) writes Mj+~Mk+1. Both set carry to the final carry-out, so for SUB a carry of 1 means no borrow.
- R5: After opcodes 0 to 4, zero is 1 exactly when the 8-bit result is 0, and negative equals result bit 7.
- R6: The destination is written only after all eight bits are computed, so i may equal j or k and the old operand values are still used.
- R7: Reading address 31 as a source yields the program counter of the instruction being executed.
- R8: An instruction that writes address 31 loads the program counter with its result (a jump). Otherwise the program counter advances by one.
- R9: Opcode 7 copies Mj to Mi only when the condition chosen by k[1:0] holds: 0 carry, 1 zero, 2 negative, 3 always. It never changes a flag. A false condition writes nothing.
- R10: Opcodes 5 and 6 change no RAM byte and no flag; only the program counter advances by one.
- R11: The program counter and the flags change only at the commit cycle that ends an instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| romAddr | output | 8 | Instruction ROM address (the program counter) |
| romData | input | 18 | Instruction word returned by the ROM |
| pcOut | output | 8 | Current program counter |
| carryFlag | output | 1 | Carry flag |
| zeroFlag | output | 1 | Zero flag |
| negFlag | output | 1 | Negative flag |
| dbgAddr | input | 5 | Test read address into RAM (31 reads the PC) |
| dbgData | output | 8 | RAM byte at dbgAddr |

## Verification
A wrong bit counter or a carry that is not seeded correctly shows up in the RAM byte and flags that the test port reads back at the next instruction boundary, ten cycles after fetch. A stale program counter or a jump that is lost shows up on `pcOut`, and also in the value that later instructions store when they read address 31. Each program therefore carries its error forward into data that can be checked. The cost is that a fault is seen at the end of the instruction, not at the bit step that caused it.

// File: rtl/bscPkg.sv
package bscPkg;
  parameter int DATA_W = 8;
  parameter int ADDR_W = 5;
  parameter int OP_W   = 3;
  localparam int INSTR_W = OP_W + 3 * ADDR_W;
  localparam int IDX_W   = $clog2(DATA_W);
  localparam int PC_W    = DATA_W;
  localparam logic [ADDR_W-1:0] PC_ALIAS = '1;

  typedef enum logic [OP_W-1:0] {
    OP_AND  = 3'd0,
    OP_OR   = 3'd1,
    OP_XOR  = 3'd2,
    OP_ADD  = 3'd3,
    OP_SUB  = 3'd4,
    OP_RSV5 = 3'd5,
    OP_RSV6 = 3'd6,
    OP_CMOV = 3'd7
  } opcode_t;

  typedef struct packed {
    logic              stepBit;
    logic              firstBit;
    logic              commit;
    logic [IDX_W-1:0]  bitIdx;
    opcode_t           op;
    logic [ADDR_W-1:0] dst;
    logic [ADDR_W-1:0] srcA;
    logic [ADDR_W-1:0] srcB;
  } ctlStrobe_t;
endpackage

// File: rtl/bscAlu.sv
module bscAlu
  import bscPkg::*;
(
  input  opcode_t op,
  input  logic    aBit,
  input  logic    bBit,
  input  logic    cIn,
  output logic    rBit,
  output logic    cOut
);
  logic bEff;

  always_comb begin
    bEff = (op == OP_SUB) ? ~bBit : bBit;
    rBit = 1'b0;
    cOut = cIn;
    unique case (op)
      OP_AND:  rBit = aBit & bBit;
      OP_OR:   rBit = aBit | bBit;
      OP_XOR:  rBit = aBit ^ bBit;
      OP_ADD, OP_SUB: begin
        rBit = aBit ^ bEff ^ cIn;
        cOut = (aBit & bEff) | (aBit & cIn) | (bEff & cIn);
      end
      OP_CMOV: rBit = aBit;
      default: rBit = 1'b0;
    endcase
  end
endmodule

// File: rtl/bscControl.sv
module bscControl
  import bscPkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] romData,
  output ctlStrobe_t         strb
);
  typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_COMMIT} state_t;

  state_t             state;
  logic [IDX_W-1:0]   bitCnt;
  logic [INSTR_W-1:0] instrReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_FETCH;
      bitCnt   <= '0;
      instrReg <= '0;
    end else begin
      unique case (state)
        ST_FETCH: begin
          instrReg <= romData;
          bitCnt   <= '0;
          state    <= ST_EXEC;
        end
        ST_EXEC: begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == IDX_W'(DATA_W - 1)) state <= ST_COMMIT;
        end
        default: state <= ST_FETCH;
      endcase
    end
  end

  always_comb begin
    strb.stepBit  = (state == ST_EXEC);
    strb.firstBit = (state == ST_EXEC) && (bitCnt == '0);
    strb.commit   = (state == ST_COMMIT);
    strb.bitIdx   = bitCnt;
    strb.op       = opcode_t'(instrReg[INSTR_W-1 -: OP_W]);
    strb.dst      = instrReg[3*ADDR_W-1 -: ADDR_W];
    strb.srcA     = instrReg[2*ADDR_W-1 -: ADDR_W];
    strb.srcB     = instrReg[ADDR_W-1:0];
  end
endmodule

// File: rtl/bscDatapath.sv
module bscDatapath
  import bscPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        strb,
  input  logic [ADDR_W-1:0] dbgAddr,
  output logic [DATA_W-1:0] dbgData,
  output logic [PC_W-1:0]   pc,
  output logic              carryFlag,
  output logic              zeroFlag,
  output logic              negFlag
);
  localparam int NUM_WORDS = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem [NUM_WORDS];
  logic [DATA_W-1:0] resReg;
  logic              cBit;
  logic              aBit, bBit, cIn, rBit, cOut;
  logic              isArith, isLogic, condOk, doWrite;

  function automatic logic readBit(input logic [ADDR_W-1:0] a,
                                   input logic [IDX_W-1:0] idx,
                                   input logic [PC_W-1:0] pcv,
                                   input logic [DATA_W-1:0] word);
    return (a == PC_ALIAS) ? pcv[idx] : word[idx];
  endfunction

  assign aBit = readBit(strb.srcA, strb.bitIdx, pc, mem[strb.srcA]);
  assign bBit = readBit(strb.srcB, strb.bitIdx, pc, mem[strb.srcB]);
  assign cIn  = strb.firstBit ? (strb.op == OP_SUB) : cBit;

  bscAlu u_alu (
    .op  (strb.op),
    .aBit(aBit),
    .bBit(bBit),
    .cIn (cIn),
    .rBit(rBit),
    .cOut(cOut)
  );

  always_comb begin
    isArith = (strb.op == OP_ADD) || (strb.op == OP_SUB);
    isLogic = (strb.op == OP_AND) || (strb.op == OP_OR) || (strb.op == OP_XOR);
    unique case (strb.srcB[1:0])
      2'd0:    condOk = carryFlag;
      2'd1:    condOk = zeroFlag;
      2'd2:    condOk = negFlag;
      default: condOk = 1'b1;
    endcase
    doWrite = isArith || isLogic || ((strb.op == OP_CMOV) && condOk);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resReg <= '0;
      cBit   <= 1'b0;
    end else if (strb.stepBit) begin
      resReg <= {rBit, resReg[DATA_W-1:1]};
      cBit   <= cOut;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      carryFlag <= 1'b0;
      zeroFlag  <= 1'b0;
      negFlag   <= 1'b0;
    end else if (strb.commit) begin
      if (doWrite && (strb.dst == PC_ALIAS)) pc <= resReg;
      else                                   pc <= pc + 1'b1;
      if (isArith || isLogic) begin
        zeroFlag <= (resReg == '0);
        negFlag  <= resReg[DATA_W-1];
      end
      if (isArith) carryFlag <= cBit;
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) mem[w] <= '0;
      else if (strb.commit && doWrite && (strb.dst == ADDR_W'(w)) && (strb.dst != PC_ALIAS))
        mem[w] <= resReg;
    end
  end

  assign dbgData = (dbgAddr == PC_ALIAS) ? pc : mem[dbgAddr];
endmodule

// File: rtl/bitSerialCpu.sv
module bitSerialCpu
  import bscPkg::*;
(
  input  logic               clk,
  input  logic               rst,
  output logic [PC_W-1:0]    romAddr,
  input  logic [INSTR_W-1:0] romData,
  output logic [PC_W-1:0]    pcOut,
  output logic               carryFlag,
  output logic               zeroFlag,
  output logic               negFlag,
  input  logic [ADDR_W-1:0]  dbgAddr,
  output logic [DATA_W-1:0]  dbgData
);
  ctlStrobe_t strb;

  bscControl u_ctl (
    .clk    (clk),
    .rst    (rst),
    .romData(romData),
    .strb   (strb)
  );

  bscDatapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .dbgAddr  (dbgAddr),
    .dbgData  (dbgData),
    .pc       (pcOut),
    .carryFlag(carryFlag),
    .zeroFlag (zeroFlag),
    .negFlag  (negFlag)
  );

  assign romAddr = pcOut;
endmodule

// File: rtl/bscChecker.sv
module bscChecker
  import bscPkg::*;
(
  input logic            clk,
  input logic            rst,
  input ctlStrobe_t      strb,
  input logic [PC_W-1:0] pcOut,
  input logic            carryFlag,
  input logic            zeroFlag,
  input logic            negFlag
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (pcOut == '0) && !carryFlag && !zeroFlag && !negFlag); // R1

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.stepBit, strb.commit})); // R2

  AST_PC_ONLY_AT_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !strb.commit |=> $stable(pcOut)); // R11

  AST_FLAGS_ONLY_AT_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !strb.commit |=> $stable({carryFlag, zeroFlag, negFlag})); // R11

  AST_RSV_ONLY_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    strb.commit && ((strb.op == OP_RSV5) || (strb.op == OP_RSV6))
    |=> (pcOut == PC_W'($past(pcOut) + 1'b1)) && $stable({carryFlag, zeroFlag, negFlag})); // R10

  AST_CMOV_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    strb.commit && (strb.op == OP_CMOV) |=> $stable({carryFlag, zeroFlag, negFlag})); // R9

  AST_LOGIC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
    strb.commit && ((strb.op == OP_AND) || (strb.op == OP_OR) || (strb.op == OP_XOR))
    |=> $stable(carryFlag)); // R3

  AST_STEP_ADVANCES_PC: assert property (@(posedge clk) disable iff (rst)
    strb.commit && (strb.dst != PC_ALIAS) |=> (pcOut == PC_W'($past(pcOut) + 1'b1))); // R8
endmodule

bind bitSerialCpu bscChecker u_chk (
  .clk      (clk),
  .rst      (rst),
  .strb     (strb),
  .pcOut    (pcOut),
  .carryFlag(carryFlag),
  .zeroFlag (zeroFlag),
  .negFlag  (negFlag)
);

// File: tb/sim_bitSerialCpu.sv
`timescale 1ns/1ps
module sim_bitSerialCpu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  romAddr;
  logic [17:0] romData;
  logic [7:0]  pcOut;
  logic        carryFlag, zeroFlag, negFlag;
  logic [4:0]  dbgAddr = '0;
  logic [7:0]  dbgData;
  logic [17:0] rom [256];

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  assign romData = rom[romAddr];

  bitSerialCpu u0 (
    .clk(clk), .rst(rst), .romAddr(romAddr), .romData(romData),
    .pcOut(pcOut), .carryFlag(carryFlag), .zeroFlag(zeroFlag), .negFlag(negFlag),
    .dbgAddr(dbgAddr), .dbgData(dbgData)
  );

  localparam logic [4:0] PCA = 5'd31;

  function automatic logic [17:0] enc(input logic [2:0] op, input logic [4:0] i,
                                      input logic [4:0] j, input logic [4:0] k);
    return {op, i, j, k};
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clearRom();
    for (int a = 0; a < 256; a++) rom[a] = enc(3'd5, 5'd0, 5'd0, 5'd0);
  endtask

  task automatic doReset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic runInstr(input int n);
    repeat (10 * n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkMem(input string req, input logic [4:0] a, input logic [7:0] exp);
    dbgAddr = a;
    #0.5;
    check(req, $sformatf("M%0d", a), dbgData, exp);
  endtask

  task automatic checkFlags(input string req, input bit c, input bit z, input bit n);
    check(req, "flags CZN", {carryFlag, zeroFlag, negFlag}, {c, z, n});
  endtask

  task automatic testArith();
    clearRom();
    rom[1] = enc(3'd4, 5'd1, 5'd0, PCA);   // M1 = 0 - 1 = FF
    rom[2] = enc(3'd3, 5'd2, 5'd1, PCA);   // M2 = FF + 2 = 01, carry
    rom[3] = enc(3'd2, 5'd3, 5'd1, PCA);   // M3 = FF ^ 3 = FC
    rom[4] = enc(3'd0, 5'd4, 5'd3, PCA);   // M4 = FC & 4 = 04
    rom[5] = enc(3'd4, 5'd5, 5'd4, 5'd4);  // M5 = 4 - 4 = 0
    doReset();
    runInstr(1);
    check("R2", "pc after one instr", pcOut, 1);
    runInstr(1);
    checkMem("R4", 5'd1, 8'hFF);
    checkFlags("R4", 1'b0, 1'b0, 1'b1);
    runInstr(1);
    checkMem("R4", 5'd2, 8'h01);
    checkFlags("R5", 1'b1, 1'b0, 1'b0);
    runInstr(1);
    checkMem("R3", 5'd3, 8'hFC);
    checkFlags("R3", 1'b1, 1'b0, 1'b1);
    runInstr(1);
    checkMem("R3", 5'd4, 8'h04);
    runInstr(1);
    checkMem("R5", 5'd5, 8'h00);
    checkFlags("R5", 1'b1, 1'b1, 1'b0);
    check("R8", "pc after six", pcOut, 6);
  endtask

  task automatic testOverlap();
    clearRom();
    rom[1] = enc(3'd1, 5'd1, PCA, PCA);    // M1 = 1 (R7)
    rom[2] = enc(3'd3, 5'd1, 5'd1, 5'd1);  // M1 = 2
    rom[3] = enc(3'd3, 5'd1, 5'd1, 5'd1);  // M1 = 4
    rom[4] = enc(3'd4, 5'd1, PCA, 5'd1);   // M1 = 4 - 4 = 0
    rom[5] = enc(3'd4, 5'd1, PCA, 5'd1);   // M1 = 5 - 0 = 5
    doReset();
    runInstr(2);
    checkMem("R7", 5'd1, 8'h01);
    runInstr(2);
    checkMem("R6", 5'd1, 8'h04);
    runInstr(2);
    checkMem("R6", 5'd1, 8'h05);
    checkFlags("R6", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testJump();
    clearRom();
    rom[1] = enc(3'd1, 5'd1, PCA, PCA);    // M1 = 1
    rom[2] = enc(3'd3, 5'd2, PCA, PCA);    // M2 = 4
    rom[3] = enc(3'd3, PCA, 5'd2, PCA);    // jump to 4 + 3 = 7
    rom[4] = enc(3'd1, 5'd3, PCA, PCA);    // skipped
    rom[7] = enc(3'd1, 5'd4, PCA, PCA);    // M4 = 7
    doReset();
    runInstr(4);
    check("R8", "pc after jump", pcOut, 7);
    checkMem("R8", PCA, 8'h07);
    runInstr(1);
    checkMem("R8", 5'd3, 8'h00);
    checkMem("R7", 5'd4, 8'h07);
    check("R8", "pc after landing", pcOut, 8);
  endtask

  task automatic testCmov();
    clearRom();
    rom[1] = enc(3'd4, 5'd1, 5'd0, PCA);   // M1 = FF, C0 Z0 N1
    rom[2] = enc(3'd7, 5'd2, 5'd1, 5'd0);  // carry clear: no move
    rom[3] = enc(3'd7, 5'd3, 5'd1, 5'd2);  // negative set: move
    rom[4] = enc(3'd7, 5'd4, PCA, 5'd3);   // always: M4 = 4
    rom[5] = enc(3'd7, 5'd5, 5'd1, 5'd1);  // zero clear: no move
    rom[6] = enc(3'd3, 5'd6, PCA, PCA);    // M6 = 12, flags C0 Z0 N0
    rom[7] = enc(3'd7, PCA, 5'd6, 5'd3);   // always jump to 12
    rom[8] = enc(3'd1, 5'd7, PCA, PCA);    // skipped
    doReset();
    runInstr(6);
    checkMem("R9", 5'd2, 8'h00);
    checkMem("R9", 5'd3, 8'hFF);
    checkMem("R9", 5'd4, 8'h04);
    checkMem("R9", 5'd5, 8'h00);
    checkFlags("R9", 1'b0, 1'b0, 1'b1);
    runInstr(2);
    check("R9", "pc after cond jump", pcOut, 12);
    checkMem("R9", 5'd7, 8'h00);
  endtask

  task automatic testReserved();
    clearRom();
    rom[1] = enc(3'd4, 5'd1, 5'd0, PCA);   // M1 = FF, C0 Z0 N1
    rom[2] = enc(3'd6, 5'd1, PCA, PCA);
    rom[3] = enc(3'd5, 5'd2, PCA, PCA);
    doReset();
    runInstr(4);
    checkMem("R10", 5'd1, 8'hFF);
    checkMem("R10", 5'd2, 8'h00);
    checkFlags("R10", 1'b0, 1'b0, 1'b1);
    check("R10", "pc", pcOut, 4);
  endtask

  task automatic testReset();
    int bad = 0;
    doReset();
    check("R1", "pc", pcOut, 0);
    checkFlags("R1", 1'b0, 1'b0, 1'b0);
    for (int a = 0; a < 31; a++) begin
      dbgAddr = 5'(a);
      #0.5;
      if (dbgData != 8'h00) bad++;
    end
    check("R1", "nonzero RAM bytes", bad, 0);
  endtask

  initial begin
    clearRom();
    doReset();
    check("R1", "pc at start", pcOut, 0);
    testArith();
    testOverlap();
    testJump();
    testCmov();
    testReserved();
    testReset();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule